// File: doc/BRIEF.md
# Scatter-Gather Multi-Channel Buffer Writer

This block sits behind a scan sequencer that produces one 32-bit sample at a time, each tagged with a channel number. For every channel whose DMA enable is set, it forms a host byte address and issues a write through a simple request/acknowledge memory port. Host buffers are described by a scatter-gather table. Each row of the table holds one buffer base per channel, plus two row flags: one requests an interrupt when the buffer fills, and one sends the walk back to row 0.

All channels share one row index and one byte offset, so the data captured from every channel stays aligned buffer for buffer. The offset steps by four bytes each time the sequencer marks the end of a scan. When a buffer fills, the offset returns to zero and the row index advances. The counters move whether or not any channel is enabled, and a reset clears the counters but leaves the table untouched. A channel whose previous write has not been acknowledged when its next sample arrives is flagged with a sticky error bit, which marks a gap in that channel's data.

Top module: `sg_buf_writer`

## Requirements
- R1: Table rows written through the table port (base per row and channel, flags per row, taken from the same write) survive a reset: after reset the first write uses the base stored before the reset.
- R2: A write address is the table base of the current row for the sample's channel in bits ADDR_W-1:BUF_AW, with the shared byte offset in bits BUF_AW-1:0. After reset the row is 0 and the offset is 0.
- R3: A valid sample with smp_last_i set (end of scan) adds 4 to the offset. If the offset equals 2^BUF_AW-4 at that point, the buffer is full: the offset returns to 0 and the row advances. No other input changes the offset.
- R4: When a buffer fills, the next row is 0 if the filled row has its last flag set or is row ROWS-1. Otherwise the next row is the filled row plus one.
- R5: The row and offset advance with end-of-scan samples even while dma_en_i is all zero. A sample from a channel whose enable bit is 0 produces no memory write.
- R6: When a buffer fills in a row whose interrupt flag is set, irq_o is high for exactly the one cycle after that clock edge, and irq_row_o gives the filled row. Filling a row without the flag gives no pulse.
- R7: Each enabled sample is held as a pending write for its channel. mem_req_o is high while any write is pending. The lowest-numbered pending channel's address and data are presented, and they are held until mem_ack_i is sampled high.
- R8: An enabled sample for a channel that still holds an unacknowledged write sets that channel's bit of dma_err_o, which stays set until reset, and the new sample replaces the old one. If the old write is acknowledged on the same edge, no error is raised.
- R9: During and just after reset, mem_req_o, irq_o and dma_err_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample present this cycle |
| smp_ch_i | input | CH_W | Channel of the sample |
| smp_last_i | input | 1 | Sample ends the current scan |
| smp_data_i | input | DATA_W | Sample value |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_row_i | input | ROW_W | Table row to write |
| tbl_ch_i | input | CH_W | Channel entry to write |
| tbl_base_i | input | ADDR_W-BUF_AW | Buffer base (address bits above the offset) |
| tbl_irq_i | input | 1 | Row interrupt-on-fill flag |
| tbl_last_i | input | 1 | Row last flag (wrap to row 0 after fill) |
| dma_en_i | input | NUM_CH | Per-channel DMA enable |
| mem_req_o | output | 1 | Memory write request |
| mem_addr_o | output | ADDR_W | Write byte address |
| mem_data_o | output | DATA_W | Write data |
| mem_ack_i | input | 1 | Write accepted |
| irq_o | output | 1 | Buffer-full interrupt pulse |
| irq_row_o | output | ROW_W | Row whose buffer filled |
| dma_err_o | output | NUM_CH | Sticky per-channel overrun error |

## Verification
A wrong shared offset or row shows up in the address of the next write from any enabled channel. It is visible as soon as the request appears, one cycle after the sample edge, and an error in the wrap shows up at the first sample of the following buffer. A wrong fill decision also moves the irq_o pulse to the wrong cycle or the wrong row, which is seen in the cycle right after the filling edge. Pending-slot faults show as a lost, duplicated or misordered request, or as an error bit that is missing or spurious, on the edge where the colliding sample lands.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int unsigned SMP_BYTES = 4;

  typedef struct packed {
    logic irq;
    logic last;
  } sgw_flags_t;
endpackage

// File: rtl/sgw_table.sv
module sgw_table
  import sgw_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ROWS   = 64,
  parameter int unsigned BASE_W = 20,
  localparam int unsigned CH_W  = $clog2(NUM_CH),
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  wr_row_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [BASE_W-1:0] wr_base_i,
  input  sgw_flags_t        wr_flags_i,
  input  logic [ROW_W-1:0]  rd_row_i,
  input  logic [CH_W-1:0]   rd_ch_i,
  output logic [BASE_W-1:0] rd_base_o,
  output sgw_flags_t        rd_flags_o
);
  // Contents deliberately carry no reset.
  logic [BASE_W-1:0] base_mem [ROWS][NUM_CH];
  sgw_flags_t        flag_mem [ROWS];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      base_mem[wr_row_i][wr_ch_i] <= wr_base_i;
      flag_mem[wr_row_i]          <= wr_flags_i;
    end
  end

  assign rd_base_o  = base_mem[rd_row_i][rd_ch_i];
  assign rd_flags_o = flag_mem[rd_row_i];
endmodule

// File: rtl/sgw_cursor.sv
module sgw_cursor
  import sgw_pkg::*;
#(
  parameter int unsigned ROWS   = 64,
  parameter int unsigned BUF_AW = 12,
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  sgw_flags_t        flags_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [BUF_AW-1:0] off_o,
  output logic              irq_o,
  output logic [ROW_W-1:0]  irq_row_o
);
  localparam logic [BUF_AW-1:0] OFF_STEP = BUF_AW'(SMP_BYTES);
  localparam logic [BUF_AW-1:0] OFF_LAST = BUF_AW'((2 ** BUF_AW) - SMP_BYTES);
  localparam logic [ROW_W-1:0]  ROW_MAX  = ROW_W'(ROWS - 1);

  logic             full;
  logic [ROW_W-1:0] row_nxt;

  assign full    = step_i && (off_o == OFF_LAST);
  assign row_nxt = (flags_i.last || row_o == ROW_MAX) ? '0 : row_o + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_o     <= '0;
      off_o     <= '0;
      irq_o     <= 1'b0;
      irq_row_o <= '0;
    end else begin
      irq_o <= 1'b0;
      if (full) begin
        off_o     <= '0;
        row_o     <= row_nxt;
        irq_o     <= flags_i.irq;
        irq_row_o <= row_o;
      end else if (step_i) begin
        off_o <= off_o + OFF_STEP;
      end
    end
  end
endmodule

// File: rtl/sgw_slots.sv
module sgw_slots #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_CH-1:0]             load_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             data_i,
  input  logic [NUM_CH-1:0]             done_i,
  output logic [NUM_CH-1:0]             pend_o,
  output logic [NUM_CH-1:0][ADDR_W-1:0] addr_o,
  output logic [NUM_CH-1:0][DATA_W-1:0] data_o,
  output logic [NUM_CH-1:0]             err_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_o[c] <= 1'b0;
        err_o[c]  <= 1'b0;
        addr_o[c] <= '0;
        data_o[c] <= '0;
      end else if (load_i[c]) begin
        // Overrun: previous write still outstanding and not retired now.
        if (pend_o[c] && !done_i[c]) err_o[c] <= 1'b1;
        pend_o[c] <= 1'b1;
        addr_o[c] <= addr_i;
        data_o[c] <= data_i;
      end else if (done_i[c]) begin
        pend_o[c] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sgw_arb.sv
module sgw_arb #(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] pend_i,
  output logic [NUM_CH-1:0] gnt_oh_o,
  output logic [CH_W-1:0]   gnt_idx_o,
  output logic              any_o
);
  always_comb begin
    gnt_oh_o  = '0;
    gnt_idx_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        gnt_oh_o  = '0;
        gnt_oh_o[i] = 1'b1;
        gnt_idx_o = CH_W'(i);
      end
    end
  end

  assign any_o = |pend_i;
endmodule

// File: rtl/sg_buf_writer.sv
module sg_buf_writer
  import sgw_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ROWS   = 64,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BUF_AW = 12,
  localparam int unsigned CH_W   = $clog2(NUM_CH),
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned BASE_W = ADDR_W - BUF_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [CH_W-1:0]   smp_ch_i,
  input  logic              smp_last_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic              tbl_we_i,
  input  logic [ROW_W-1:0]  tbl_row_i,
  input  logic [CH_W-1:0]   tbl_ch_i,
  input  logic [BASE_W-1:0] tbl_base_i,
  input  logic              tbl_irq_i,
  input  logic              tbl_last_i,
  input  logic [NUM_CH-1:0] dma_en_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  input  logic              mem_ack_i,
  output logic              irq_o,
  output logic [ROW_W-1:0]  irq_row_o,
  output logic [NUM_CH-1:0] dma_err_o
);
  logic [ROW_W-1:0]              cur_row;
  logic [BUF_AW-1:0]             cur_off;
  logic [BASE_W-1:0]             rd_base;
  sgw_flags_t                    rd_flags;
  sgw_flags_t                    wr_flags;
  logic [NUM_CH-1:0]             load;
  logic [NUM_CH-1:0]             done;
  logic [NUM_CH-1:0]             pend;
  logic [NUM_CH-1:0]             gnt_oh;
  logic [CH_W-1:0]               gnt_idx;
  logic [NUM_CH-1:0][ADDR_W-1:0] slot_addr;
  logic [NUM_CH-1:0][DATA_W-1:0] slot_data;
  logic [ADDR_W-1:0]             smp_addr;

  assign wr_flags = '{irq: tbl_irq_i, last: tbl_last_i};

  sgw_table #(
    .NUM_CH (NUM_CH),
    .ROWS   (ROWS),
    .BASE_W (BASE_W)
  ) u_table (
    .clk_i      (clk_i),
    .we_i       (tbl_we_i),
    .wr_row_i   (tbl_row_i),
    .wr_ch_i    (tbl_ch_i),
    .wr_base_i  (tbl_base_i),
    .wr_flags_i (wr_flags),
    .rd_row_i   (cur_row),
    .rd_ch_i    (smp_ch_i),
    .rd_base_o  (rd_base),
    .rd_flags_o (rd_flags)
  );

  sgw_cursor #(
    .ROWS   (ROWS),
    .BUF_AW (BUF_AW)
  ) u_cursor (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (smp_valid_i && smp_last_i),
    .flags_i   (rd_flags),
    .row_o     (cur_row),
    .off_o     (cur_off),
    .irq_o     (irq_o),
    .irq_row_o (irq_row_o)
  );

  assign smp_addr = {rd_base, cur_off};

  always_comb begin
    load = '0;
    if (smp_valid_i) load[smp_ch_i] = dma_en_i[smp_ch_i];
  end

  assign done = mem_ack_i ? gnt_oh : '0;

  sgw_slots #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_slots (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .addr_i (smp_addr),
    .data_i (smp_data_i),
    .done_i (done),
    .pend_o (pend),
    .addr_o (slot_addr),
    .data_o (slot_data),
    .err_o  (dma_err_o)
  );

  sgw_arb #(
    .NUM_CH (NUM_CH)
  ) u_arb (
    .pend_i    (pend),
    .gnt_oh_o  (gnt_oh),
    .gnt_idx_o (gnt_idx),
    .any_o     (mem_req_o)
  );

  assign mem_addr_o = slot_addr[gnt_idx];
  assign mem_data_o = slot_data[gnt_idx];
endmodule

// File: rtl/sg_buf_writer_chk.sv
module sg_buf_writer_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BUF_AW = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              smp_valid_i,
  input logic              smp_last_i,
  input logic [NUM_CH-1:0] dma_en_i,
  input logic              mem_req_o,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              irq_o,
  input logic [NUM_CH-1:0] dma_err_o,
  input logic [BUF_AW-1:0] cur_off
);
  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o);

  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((dma_err_o & $past(dma_err_o)) == $past(dma_err_o)));

  // R6
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R3
  off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(smp_valid_i && smp_last_i) |=> $stable(cur_off));

  // R2
  addr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  // R5
  dis_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_en_i == '0) && !mem_req_o |=> !mem_req_o);
endmodule

bind sg_buf_writer sg_buf_writer_chk #(
  .NUM_CH (NUM_CH),
  .ADDR_W (ADDR_W),
  .BUF_AW (BUF_AW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_valid_i (smp_valid_i),
  .smp_last_i  (smp_last_i),
  .dma_en_i    (dma_en_i),
  .mem_req_o   (mem_req_o),
  .mem_ack_i   (mem_ack_i),
  .mem_addr_o  (mem_addr_o),
  .irq_o       (irq_o),
  .dma_err_o   (dma_err_o),
  .cur_off     (cur_off)
);

// File: tb/sg_buf_writer_tb.sv
module sg_buf_writer_tb;
  localparam int NCH = 4;
  localparam int NROW = 4;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BAW = 4;
  localparam int BW = AW - BAW;
  localparam int OFF_LAST = (2 ** BAW) - 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_valid = 1'b0;
  logic [1:0]    smp_ch = '0;
  logic          smp_last = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic          tbl_we = 1'b0;
  logic [1:0]    tbl_row = '0;
  logic [1:0]    tbl_ch = '0;
  logic [BW-1:0] tbl_base = '0;
  logic          tbl_irq = 1'b0;
  logic          tbl_last = 1'b0;
  logic [NCH-1:0] dma_en = '0;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic          mem_ack = 1'b0;
  logic          irq;
  logic [1:0]    irq_row;
  logic [NCH-1:0] dma_err;

  always #2 clk = ~clk;

  sg_buf_writer #(
    .NUM_CH (NCH), .ROWS (NROW), .ADDR_W (AW), .DATA_W (DW), .BUF_AW (BAW)
  ) u_dut (
    .clk_i (clk), .rst_ni (rst_n),
    .smp_valid_i (smp_valid), .smp_ch_i (smp_ch), .smp_last_i (smp_last), .smp_data_i (smp_data),
    .tbl_we_i (tbl_we), .tbl_row_i (tbl_row), .tbl_ch_i (tbl_ch), .tbl_base_i (tbl_base),
    .tbl_irq_i (tbl_irq), .tbl_last_i (tbl_last), .dma_en_i (dma_en),
    .mem_req_o (mem_req), .mem_addr_o (mem_addr), .mem_data_o (mem_data), .mem_ack_i (mem_ack),
    .irq_o (irq), .irq_row_o (irq_row), .dma_err_o (dma_err)
  );

  int tests = 0;
  int fails = 0;

  // Bench-side table copy and reference state
  logic [BW-1:0] bt [NROW][NCH];
  logic          fi [NROW];
  logic          fl [NROW];
  logic          m_pend [NCH];
  logic [AW-1:0] m_addr [NCH];
  logic [DW-1:0] m_data [NCH];
  logic [NCH-1:0] m_err;
  int            m_row, m_off, m_irq_row;
  logic          m_irq;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input int row, input int off, input int ch);
    return {bt[row][ch], BAW'(off)};
  endfunction

  function automatic int next_row(input int row);
    if (fl[row] || row == NROW - 1) return 0;
    return row + 1;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) m_pend[c] = 1'b0;
    m_err = '0; m_row = 0; m_off = 0; m_irq = 1'b0; m_irq_row = 0;
  endtask

  task automatic compare();
    int g;
    g = -1;
    for (int c = NCH - 1; c >= 0; c--) if (m_pend[c]) g = c;
    chk(mem_req == (g >= 0), "R7 req", 64'(mem_req), 64'(g >= 0));
    if (g >= 0) begin
      chk(mem_addr == m_addr[g], "R2,R3,R4 addr", 64'(mem_addr), 64'(m_addr[g]));
      chk(mem_data == m_data[g], "R7 data", 64'(mem_data), 64'(m_data[g]));
    end
    chk(dma_err == m_err, "R8 err", 64'(dma_err), 64'(m_err));
    chk(irq == m_irq, "R6 irq", 64'(irq), 64'(m_irq));
    if (m_irq) chk(irq_row == 2'(m_irq_row), "R6 row", 64'(irq_row), 64'(m_irq_row));
  endtask

  task automatic step(input logic v, input int ch, input logic last, input logic [DW-1:0] d, input logic ack);
    logic ack_e;
    int g;
    @(negedge clk);
    ack_e = ack & mem_req;
    smp_valid = v; smp_ch = 2'(ch); smp_last = last; smp_data = d; mem_ack = ack_e;
    @(posedge clk);
    #1;
    g = -1;
    for (int c = NCH - 1; c >= 0; c--) if (m_pend[c]) g = c;
    if (ack_e && g >= 0) m_pend[g] = 1'b0;
    if (v && dma_en[ch]) begin
      if (m_pend[ch]) m_err[ch] = 1'b1;
      m_pend[ch] = 1'b1;
      m_addr[ch] = exp_addr(m_row, m_off, ch);
      m_data[ch] = d;
    end
    m_irq = 1'b0;
    if (v && last) begin
      if (m_off == OFF_LAST) begin
        m_irq = fi[m_row];
        m_irq_row = m_row;
        m_row = next_row(m_row);
        m_off = 0;
      end else begin
        m_off += 4;
      end
    end
    compare();
  endtask

  task automatic idle(input logic ack);
    step(1'b0, 0, 1'b0, '0, ack);
  endtask

  task automatic scan();
    for (int c = 0; c < NCH; c++) step(1'b1, c, c == NCH - 1, $urandom, 1'b1);
  endtask

  task automatic tbl_write(input int row, input int ch, input logic [BW-1:0] base, input logic fir, input logic fla);
    @(negedge clk);
    tbl_we = 1'b1; tbl_row = 2'(row); tbl_ch = 2'(ch); tbl_base = base; tbl_irq = fir; tbl_last = fla;
    smp_valid = 1'b0; mem_ack = 1'b0;
    @(posedge clk);
    #1;
    bt[row][ch] = base; fi[row] = fir; fl[row] = fla;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_valid = 1'b0; mem_ack = 1'b0;
    model_reset();
    #1;
    // R9
    chk(!mem_req && !irq && dma_err == '0, "R9 reset", {mem_req, irq, dma_err}, '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(!mem_req && !irq && dma_err == '0, "R9 after", {mem_req, irq, dma_err}, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < NROW; r++)
      for (int c = 0; c < NCH; c++)
        tbl_write(r, c, BW'($urandom), (r % 2) == 1, 1'b0);
    do_reset();

    // R2 / R3 / R6: walk rows with ch0 enabled
    dma_en = 4'b0001;
    step(1'b1, 0, 1'b0, 32'hA5A5_0001, 1'b0);
    chk(mem_addr == exp_addr(0, 0, 0), "R2 first addr", 64'(mem_addr), 64'(exp_addr(0, 0, 0)));
    for (int c = 1; c < NCH; c++) step(1'b1, c, c == NCH - 1, $urandom, 1'b1);
    for (int s = 1; s < 4; s++) scan();
    chk(!irq, "R6 unflagged row", 64'(irq), 0);
    step(1'b1, 0, 1'b0, 32'h1, 1'b0);
    chk(mem_addr == exp_addr(1, 0, 0), "R3 row advance", 64'(mem_addr), 64'(exp_addr(1, 0, 0)));
    for (int c = 1; c < NCH; c++) step(1'b1, c, c == NCH - 1, $urandom, 1'b1);
    for (int s = 1; s < 4; s++) scan();
    chk(irq && irq_row == 2'd1, "R6 flagged row", {irq, irq_row}, {1'b1, 2'd1});
    idle(1'b1);
    chk(!irq, "R6 one cycle", 64'(irq), 0);

    // R4: last flag on row 2 returns to row 0
    tbl_write(2, 0, bt[2][0], 1'b0, 1'b1);
    for (int s = 0; s < 4; s++) scan();
    step(1'b1, 0, 1'b0, 32'h2, 1'b0);
    chk(mem_addr == exp_addr(0, 0, 0), "R4 last flag", 64'(mem_addr), 64'(exp_addr(0, 0, 0)));
    for (int c = 1; c < NCH; c++) step(1'b1, c, c == NCH - 1, $urandom, 1'b1);
    tbl_write(2, 0, bt[2][0], 1'b0, 1'b0);
    for (int s = 1; s < 16; s++) scan();
    step(1'b1, 0, 1'b0, 32'h3, 1'b0);
    chk(mem_addr == exp_addr(0, 0, 0), "R4 wrap at end", 64'(mem_addr), 64'(exp_addr(0, 0, 0)));
    for (int c = 1; c < NCH; c++) step(1'b1, c, c == NCH - 1, $urandom, 1'b1);
    idle(1'b1);

    // R5: counters advance while disabled
    dma_en = '0;
    for (int s = 0; s < 5; s++) scan();
    chk(!mem_req, "R5 no write", 64'(mem_req), 0);
    dma_en = 4'b0100;
    step(1'b1, 2, 1'b0, 32'h4, 1'b0);
    chk(mem_addr == exp_addr(1, 8, 2), "R5 shared advance", 64'(mem_addr), 64'(exp_addr(1, 8, 2)));

    // R8: overrun and same-edge retire
    step(1'b1, 2, 1'b0, 32'hDEAD_0005, 1'b0);
    chk(dma_err == 4'b0100, "R8 overrun", 64'(dma_err), 64'h4);
    chk(mem_data == 32'hDEAD_0005, "R8 replace", 64'(mem_data), 64'hDEAD_0005);
    idle(1'b0);
    chk(dma_err == 4'b0100, "R8 sticky", 64'(dma_err), 64'h4);
    do_reset();
    dma_en = 4'b0010;
    step(1'b1, 1, 1'b0, 32'h6, 1'b0);
    step(1'b1, 1, 1'b0, 32'h7, 1'b1);
    chk(dma_err == '0 && mem_req && mem_data == 32'h7, "R8 same edge", {dma_err, mem_req, mem_data}, {4'b0, 1'b1, 32'h7});
    idle(1'b1);

    // R1: table survives reset
    do_reset();
    dma_en = 4'b1000;
    step(1'b1, 3, 1'b0, 32'h8, 1'b0);
    chk(mem_addr == exp_addr(0, 0, 3), "R1 table kept", 64'(mem_addr), 64'(exp_addr(0, 0, 3)));
    idle(1'b1);

    // Random phase
    tbl_write(1, 2, bt[1][2], 1'b1, 1'b1);
    begin
      int ch = 0;
      for (int i = 0; i < 4000; i++) begin
        logic v;
        if (($urandom % 32) == 0) dma_en = 4'($urandom);
        v = ($urandom % 10) < 7;
        step(v, ch, v && ch == NCH - 1, $urandom, ($urandom % 3) != 0);
        if (v) ch = (ch + 1) % NCH;
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule